// File: doc/BRIEF.md
# Data-Memory Load/Store Slot

This block is the memory lane of a four-lane wide-issue core. Each cycle it may accept one decoded request: a load, which reads a 32-bit word and returns it with a destination register index for write-back, or a store, which writes a full 32-bit register value into the local data memory. The block owns a 1024-word by 32-bit data array. It also owns the latency pipeline that gives loads a one-cycle turnaround and stores a three-cycle commit.

The effective address comes from one of three modes: a zero-extended 16-bit literal, a register value, or a register value plus a sign-extended 5-bit offset. Addresses count half-word units, so two consecutive address values select the same word. The word index is taken from address bits [10:1]. Higher bits are dropped, so any address wraps modulo the memory size. A load that targets a word with a store still in its commit pipeline receives the data of the youngest such store, so back-to-back store/load pairs never stall.

Top module: `lsu_mem_slot`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `wb_valid` is 0, `busy` is 0 and `wb_data` is 0.
- R2: With `req_mode` = 2'b00 (absolute), the effective address is `req_imm` zero-extended to 32 bits.
- R3: With `req_mode` = 2'b01 (register), the effective address is `req_base`. The code 2'b11 behaves the same as 2'b01.
- R4: With `req_mode` = 2'b10 (indexed), the effective address is `req_base` plus `req_imm[4:0]` sign-extended, computed modulo 2^32.
- R5: The word accessed is effective-address bits [10:1]. Bit 0 and bits above 10 have no effect, so addresses wrap modulo 1024 words.
- R6: A load accepted at a clock edge (`req_valid`=1, `req_store`=0) raises `wb_valid` for exactly the following cycle, with `wb_rd` equal to the request's `req_rd` and `wb_data` equal to the word.
- R7: A store accepted at a clock edge (`req_store`=1) raises no `wb_valid`. It keeps `busy` at 1 for the three cycles after that edge, and it commits `req_sdata` to memory at the third edge after acceptance.
- R8: A load to a word with one or more stores still in flight returns the data of the youngest such store. A load to any other word returns the memory contents.
- R9: A cycle with `req_valid`=0 changes no memory word and raises no `wb_valid`, whatever the other request inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | Address mode: 00 absolute, 01 register, 10 indexed, 11 register |
| req_imm | input | 16 | Literal address (absolute) or offset in bits [4:0] (indexed) |
| req_base | input | 32 | Base register value |
| req_sdata | input | 32 | Store data |
| req_rd | input | 5 | Destination register of a load |
| wb_valid | output | 1 | Load result valid this cycle |
| wb_rd | output | 5 | Destination register of the load result |
| wb_data | output | 32 | Load result |
| busy | output | 1 | One or more stores are still committing |

## Verification
The bench builds the block with its defaults: 1024 words, 32-bit data and a three-stage store commit. At this size the top address bit used, bit 10, and the wrap past word 1023 can be reached with small literals and bases, including a negative offset that carries through all 32 address bits. The three-stage commit lets a load be placed at each distance from a store, from the next cycle to after the commit. This tests forwarding from every pipeline stage and youngest-store priority between two stores to the same word.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    AM_ABS  = 2'b00,
    AM_REG  = 2'b01,
    AM_IDX  = 2'b10,
    AM_REGX = 2'b11
  } amode_e;

  // sign-extend a 5-bit offset to 32 bits
  function automatic logic [31:0] sext_ofs(input logic [4:0] ofs);
    return {{27{ofs[4]}}, ofs};
  endfunction

  // effective address for each mode, 32-bit modular arithmetic
  function automatic logic [31:0] eff_addr(input logic [1:0] mode,
                                           input logic [15:0] imm,
                                           input logic [31:0] base);
    logic [31:0] ea;
    case (amode_e'(mode))
      AM_ABS:  ea = {16'h0000, imm};
      AM_IDX:  ea = base + sext_ofs(imm[4:0]);
      default: ea = base;
    endcase
    return ea;
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int IDXW = 10
) (
  input  logic [1:0]      mode,
  input  logic [15:0]     imm,
  input  logic [31:0]     base,
  output logic [31:0]     ea,
  output logic [IDXW-1:0] widx
);
  import lsu_pkg::*;

  always_comb begin
    ea   = eff_addr(mode, imm, base);
    // half-word addressing: drop bit 0, keep IDXW bits above it
    widx = ea[IDXW:1];
  end

endmodule

// File: rtl/lsu_store_pipe.sv
module lsu_store_pipe #(
  parameter int DW   = 32,
  parameter int IDXW = 10,
  parameter int LAT  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [IDXW-1:0] push_idx,
  input  logic [DW-1:0]   push_data,
  input  logic [IDXW-1:0] look_idx,
  output logic            fwd_hit,
  output logic [DW-1:0]   fwd_data,
  output logic            cmt_we,
  output logic [IDXW-1:0] cmt_idx,
  output logic [DW-1:0]   cmt_data,
  output logic            inflight
);

  logic [LAT-1:0]  stg_v;
  logic [IDXW-1:0] stg_idx [LAT];
  logic [DW-1:0]   stg_dat [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stg_v[0]   <= 1'b0;
          stg_idx[0] <= '0;
          stg_dat[0] <= '0;
        end else begin
          stg_v[0]   <= push;
          stg_idx[0] <= push_idx;
          stg_dat[0] <= push_data;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stg_v[g]   <= 1'b0;
          stg_idx[g] <= '0;
          stg_dat[g] <= '0;
        end else begin
          stg_v[g]   <= stg_v[g-1];
          stg_idx[g] <= stg_idx[g-1];
          stg_dat[g] <= stg_dat[g-1];
        end
      end
    end
  end

  // youngest matching stage wins: scan oldest first, later hits overwrite
  always_comb begin
    fwd_hit  = 1'b0;
    fwd_data = '0;
    for (int i = LAT - 1; i >= 0; i--) begin
      if (stg_v[i] && (stg_idx[i] == look_idx)) begin
        fwd_hit  = 1'b1;
        fwd_data = stg_dat[i];
      end
    end
  end

  assign cmt_we   = stg_v[LAT-1];
  assign cmt_idx  = stg_idx[LAT-1];
  assign cmt_data = stg_dat[LAT-1];
  assign inflight = |stg_v;

  // R7: an accepted store is in flight on the next cycle
  a_r7_push_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> inflight);

  // R9: no push and nothing in flight means nothing can commit next cycle
  a_r9_no_spurious_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !inflight) |=> !cmt_we);

endmodule

// File: rtl/lsu_dmem.sv
module lsu_dmem #(
  parameter int DW    = 32,
  parameter int WORDS = 1024,
  localparam int IDXW = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [IDXW-1:0] widx,
  input  logic [DW-1:0]   wdata,
  input  logic [IDXW-1:0] ridx,
  output logic [DW-1:0]   rdata
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/lsu_mem_slot.sv
module lsu_mem_slot #(
  parameter int DW     = 32,
  parameter int WORDS  = 1024,
  parameter int RIDX_W = 5,
  parameter int WR_LAT = 3,
  localparam int IDXW  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_mode,
  input  logic [15:0]       req_imm,
  input  logic [31:0]       req_base,
  input  logic [DW-1:0]     req_sdata,
  input  logic [RIDX_W-1:0] req_rd,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_rd,
  output logic [DW-1:0]     wb_data,
  output logic              busy
);

  // named internal events
  logic            ld_go;
  logic            st_go;
  logic [31:0]     ea;
  logic [IDXW-1:0] widx;
  logic            fwd_hit;
  logic [DW-1:0]   fwd_data;
  logic            cmt_we;
  logic [IDXW-1:0] cmt_idx;
  logic [DW-1:0]   cmt_data;
  logic [DW-1:0]   mem_rdata;
  logic [DW-1:0]   ld_word;

  assign ld_go = req_valid && !req_store;
  assign st_go = req_valid && req_store;

  lsu_agen #(.IDXW(IDXW)) u_agen (
    .mode (req_mode),
    .imm  (req_imm),
    .base (req_base),
    .ea   (ea),
    .widx (widx)
  );

  lsu_store_pipe #(.DW(DW), .IDXW(IDXW), .LAT(WR_LAT)) u_spipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (st_go),
    .push_idx  (widx),
    .push_data (req_sdata),
    .look_idx  (widx),
    .fwd_hit   (fwd_hit),
    .fwd_data  (fwd_data),
    .cmt_we    (cmt_we),
    .cmt_idx   (cmt_idx),
    .cmt_data  (cmt_data),
    .inflight  (busy)
  );

  lsu_dmem #(.DW(DW), .WORDS(WORDS)) u_dmem (
    .clk   (clk),
    .we    (cmt_we),
    .widx  (cmt_idx),
    .wdata (cmt_data),
    .ridx  (widx),
    .rdata (mem_rdata)
  );

  assign ld_word = fwd_hit ? fwd_data : mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_rd    <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= ld_go;
      if (ld_go) begin
        wb_rd   <= req_rd;
        wb_data <= ld_word;
      end
    end
  end

  // R6: load result appears the next cycle with its register index
  a_r6_load_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ld_go |=> (wb_valid && wb_rd == $past(req_rd)));

  // R6: write-back valid lasts one cycle per load
  a_r6_wb_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(ld_go));

  // R7: stores never produce a write-back
  a_r7_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    st_go |=> !wb_valid);

  // R9: idle cycles produce nothing
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !wb_valid);

  // R8: a hit means a store to this word is still committing
  a_r8_hit_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> busy);

endmodule

// File: tb/lsu_mem_slot_test.sv
module lsu_mem_slot_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store;
  logic [1:0]  req_mode;
  logic [15:0] req_imm;
  logic [31:0] req_base, req_sdata;
  logic [4:0]  req_rd;
  logic        wb_valid;
  logic [4:0]  wb_rd;
  logic [31:0] wb_data;
  logic        busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  lsu_mem_slot uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_mode(req_mode), .req_imm(req_imm), .req_base(req_base),
    .req_sdata(req_sdata), .req_rd(req_rd), .wb_valid(wb_valid),
    .wb_rd(wb_rd), .wb_data(wb_data), .busy(busy)
  );

  // vector: {store, mode, imm, base, data(store data or expected), rd}
  localparam int NV = 11;
  localparam logic [87:0] VEC [NV] = '{
    {1'b1, 2'b00, 16'h0010, 32'h0000_0000, 32'hA1A1_0001, 5'd0},  // R2 store word 8
    {1'b0, 2'b00, 16'h0011, 32'h0000_0000, 32'hA1A1_0001, 5'd3},  // R5 bit 0 ignored
    {1'b1, 2'b01, 16'h0000, 32'h0000_0020, 32'hB2B2_0002, 5'd0},  // R3 store word 16
    {1'b0, 2'b10, 16'h0002, 32'h0000_001E, 32'hB2B2_0002, 5'd7},  // R4 positive offset
    {1'b1, 2'b10, 16'h001F, 32'h0000_07FF, 32'hC3C3_0003, 5'd0},  // R4 offset -1, word 1023
    {1'b0, 2'b00, 16'hFFFE, 32'h0000_0000, 32'hC3C3_0003, 5'd31}, // R5 high bits dropped
    {1'b0, 2'b11, 16'h0000, 32'h0000_0020, 32'hB2B2_0002, 5'd1},  // R3 code 11 as register
    {1'b1, 2'b10, 16'h001E, 32'h0000_0001, 32'hD4D4_0004, 5'd0},  // R4 wraps to 0xFFFFFFFF
    {1'b0, 2'b01, 16'h0000, 32'h0000_07FE, 32'hD4D4_0004, 5'd9},  // R5 word 1023
    {1'b1, 2'b00, 16'h0802, 32'h0000_0000, 32'hE5E5_0005, 5'd0},  // R5 wraps to word 1
    {1'b0, 2'b01, 16'h0000, 32'h8000_0003, 32'hE5E5_0005, 5'd12}  // R5 high base bits dropped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // present one request, then return at the next falling edge
  task automatic drive(input logic st, input logic [1:0] md, input logic [15:0] im,
                       input logic [31:0] bs, input logic [31:0] sd, input logic [4:0] rd);
    req_valid = 1'b1; req_store = st; req_mode = md; req_imm = im;
    req_base = bs; req_sdata = sd; req_rd = rd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    req_valid = 0; req_store = 0; req_mode = 0; req_imm = 0;
    req_base = 0; req_sdata = 0; req_rd = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 wb_valid in reset", {31'b0, wb_valid}, 32'd0);
    check("R1 busy in reset", {31'b0, busy}, 32'd0);
    check("R1 wb_data in reset", wb_data, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 wb_valid after reset", {31'b0, wb_valid}, 32'd0);
    check("R1 busy after reset", {31'b0, busy}, 32'd0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [87:0] v;
      v = VEC[k];
      drive(v[87], v[86:85], v[84:69], v[68:37], v[36:5], v[4:0]);
      if (v[87]) begin
        check($sformatf("R7 store %0d no wb", k), {31'b0, wb_valid}, 32'd0);
        idle(3);
      end else begin
        check($sformatf("R6 load %0d valid", k), {31'b0, wb_valid}, 32'd1);
        check($sformatf("R6 load %0d rd", k), {27'b0, wb_rd}, {27'b0, v[4:0]});
        check($sformatf("R5 load %0d data", k), wb_data, v[36:5]);
        idle(1);
        check($sformatf("R6 load %0d single pulse", k), {31'b0, wb_valid}, 32'd0);
      end
    end

    // R7: busy window and commit timing
    drive(1'b1, 2'b00, 16'h0040, 32'h0, 32'h1111_2222, 5'd0); // word 32
    check("R7 busy cycle 1", {31'b0, busy}, 32'd1);
    idle(1);
    check("R7 busy cycle 2", {31'b0, busy}, 32'd1);
    idle(1);
    check("R7 busy cycle 3", {31'b0, busy}, 32'd1);
    idle(1);
    check("R7 busy cleared", {31'b0, busy}, 32'd0);
    drive(1'b0, 2'b00, 16'h0040, 32'h0, 32'h0, 5'd2);
    check("R7 committed word", wb_data, 32'h1111_2222);

    // R8: store then load on the very next cycle
    drive(1'b1, 2'b00, 16'h000A, 32'h0, 32'hF1F1_0006, 5'd0);
    drive(1'b0, 2'b01, 16'h0000, 32'h0000_000B, 32'h0, 5'd4);
    check("R8 back-to-back forward", wb_data, 32'hF1F1_0006);
    check("R8 back-to-back rd", {27'b0, wb_rd}, 32'd4);
    idle(3);

    // R8: two stores to one word, youngest wins; load at oldest stage distance
    drive(1'b1, 2'b00, 16'h0014, 32'h0, 32'h0000_AAAA, 5'd0);
    drive(1'b1, 2'b10, 16'h0004, 32'h0000_0010, 32'h0000_BBBB, 5'd0);
    drive(1'b0, 2'b00, 16'h0014, 32'h0, 32'h0, 5'd5);
    check("R8 youngest store wins", wb_data, 32'h0000_BBBB);
    idle(4);
    drive(1'b0, 2'b00, 16'h0015, 32'h0, 32'h0, 5'd5);
    check("R8 final memory after both", wb_data, 32'h0000_BBBB);

    // R8: load two idle cycles after store (store in its last stage)
    drive(1'b1, 2'b00, 16'h0060, 32'h0, 32'hCAFE_0001, 5'd0);
    idle(2);
    drive(1'b0, 2'b00, 16'h0060, 32'h0, 32'h0, 5'd6);
    check("R8 forward from last stage", wb_data, 32'hCAFE_0001);
    idle(3);

    // R8: in-flight store to another word is not forwarded
    drive(1'b1, 2'b00, 16'h0070, 32'h0, 32'hDEAD_0000, 5'd0);
    drive(1'b0, 2'b00, 16'h0060, 32'h0, 32'h0, 5'd6);
    check("R8 other word unaffected", wb_data, 32'hCAFE_0001);
    idle(3);

    // R9: invalid cycle with store fields present has no effect
    req_valid = 1'b0; req_store = 1'b1; req_mode = 2'b00; req_imm = 16'h0060;
    req_sdata = 32'h0BAD_0BAD;
    @(negedge clk);
    check("R9 no wb on idle", {31'b0, wb_valid}, 32'd0);
    check("R9 no busy on idle", {31'b0, busy}, 32'd0);
    idle(3);
    drive(1'b0, 2'b00, 16'h0060, 32'h0, 32'h0, 5'd8);
    check("R9 word unchanged", wb_data, 32'hCAFE_0001);
    idle(1);

    finish_run();
  end

endmodule